// File: doc/BRIEF.md
# Integer Branch Resolver with Delay-Slot Annul

This block resolves one integer conditional branch per transfer. For each branch it takes the 4-bit condition code, the annul bit, a 22-bit word displacement, the branch's own PC and the four integer flags (negative, zero, overflow, carry). It returns three results. The first is whether the branch is taken. The second is the PC-relative target address. The third is a squash signal that tells the pipeline to cancel the instruction in the single delay slot after the branch.

Branch records flow in and results flow out over valid/ready handshakes, with one register stage between them. A record is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the outputs in the next cycle with `out_valid` high. The result stays frozen until a cycle where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a sink that never stalls gets one result per cycle. The flags are only read. They are returned unchanged beside the result so that later stages can see that a branch does not alter them.

Top module: `brc_unit`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: `in_ready` equals `!out_valid || out_ready`. A record accepted at one edge is presented with `out_valid` high after that edge.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_taken`, `out_target`, `out_squash` and `out_flags` keep their values.
- R4: Condition encoding, with `in_cond[3]` inverting the result of the low three bits: code 0 is never taken and code 8 is always taken.
- R5: Signed compares: 1 equal (Z), 2 less-or-equal (Z or (N xor V)), 3 less (N xor V). Their inverses are 9 not-equal, 10 greater and 11 greater-or-equal.
- R6: Unsigned tests: 4 less-or-equal-unsigned (C or Z) and 5 carry set (C). Their inverses are 12 greater-unsigned and 13 carry clear.
- R7: Sign and overflow tests: 6 negative (N) and 7 overflow set (V). Their inverses are 14 positive and 15 overflow clear.
- R8: `out_target` = `in_pc` + (sign-extended `in_disp` shifted left by 2), modulo 2^32. Negative displacements branch backward.
- R9: With the annul bit clear, `out_squash` is 0 for every condition.
- R10: With the annul bit set, `out_squash` is 1 when the branch is not taken. It is also 1 for the always-taken code 8. It is 0 for every other taken branch.
- R11: `out_flags` equals the `in_flags` value of the same record. The flag bit order is N=bit 3, Z=bit 2, V=bit 1, C=bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Branch record present |
| in_ready | output | 1 | Block can accept a record |
| in_cond | input | 4 | Condition code |
| in_annul | input | 1 | Annul bit |
| in_disp | input | 22 | Signed word displacement |
| in_pc | input | 32 | Address of the branch |
| in_flags | input | 4 | N, Z, V, C flags |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result |
| out_taken | output | 1 | Branch taken |
| out_target | output | 32 | Branch target address |
| out_squash | output | 1 | Cancel the delay-slot instruction |
| out_flags | output | 4 | Flags returned unchanged |

## Verification
Several properties are checked on every cycle:
- the handshake rules: ready follows the output register, accepted records show up, and stalled results stay frozen;
- that code 8 is always taken and code 0 never;
- that a squash only occurs with the annul bit set, and that a taken squash only occurs for the always code;
- that the target keeps the PC's low two bits.

The truth tables of all sixteen conditions, the exact target sum including wrap-around at the displacement extremes, and the full annul rule can only be shown by the bench, which compares random and directed records against its own model.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    BC_NEVER = 3'd0,
    BC_EQ    = 3'd1,
    BC_LE    = 3'd2,
    BC_LT    = 3'd3,
    BC_LEU   = 3'd4,
    BC_CS    = 3'd5,
    BC_NEG   = 3'd6,
    BC_VS    = 3'd7
  } base_cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;

  localparam logic [3:0] CODE_ALWAYS = 4'h8;
  localparam logic [3:0] CODE_NEVER  = 4'h0;
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [3:0] cond,
  input  cc_flags_t  flags,
  output logic       taken
);
  logic base_hit;
  logic sgn_lt;

  always_comb begin
    sgn_lt = flags.n ^ flags.v;
    unique case (base_cond_e'(cond[2:0]))
      BC_NEVER: base_hit = 1'b0;
      BC_EQ:    base_hit = flags.z;
      BC_LE:    base_hit = flags.z | sgn_lt;
      BC_LT:    base_hit = sgn_lt;
      BC_LEU:   base_hit = flags.c | flags.z;
      BC_CS:    base_hit = flags.c;
      BC_NEG:   base_hit = flags.n;
      BC_VS:    base_hit = flags.v;
      default:  base_hit = 1'b0;
    endcase
    taken = base_hit ^ cond[3];
  end

  always_comb begin
    if (!$isunknown(cond) && cond == CODE_ALWAYS)
      p_always_taken_r4: assert (taken);
    if (!$isunknown(cond) && cond == CODE_NEVER)
      p_never_taken_r4: assert (!taken);
  end
endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 22
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   target
);
  localparam int SHIFT = 2;
  localparam int EXT_W = PC_W - DISP_W - SHIFT;

  logic [PC_W-1:0] offset;

  always_comb begin
    offset = {{EXT_W{disp[DISP_W-1]}}, disp, {SHIFT{1'b0}}};
    target = pc + offset;
  end

  always_comb begin
    if (!$isunknown(pc) && !$isunknown(disp))
      p_word_align_r8: assert (target[SHIFT-1:0] == pc[SHIFT-1:0]);
  end
endmodule

// File: rtl/brc_annul_ctl.sv
module brc_annul_ctl (
  input  logic annul,
  input  logic taken,
  input  logic is_always,
  output logic squash
);
  always_comb squash = annul & (~taken | is_always);

  always_comb begin
    if (!$isunknown({annul, taken, is_always})) begin
      p_squash_needs_annul_r9: assert (!squash || annul);
      p_taken_squash_always_r10: assert (!(squash && taken) || is_always);
    end
  end
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DISP_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_cond,
  input  logic              in_annul,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [3:0]        in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_target,
  output logic              out_squash,
  output logic [3:0]        out_flags
);
  logic            taken_c;
  logic [PC_W-1:0] target_c;
  logic            squash_c;
  logic            is_always;
  logic            accept;

  brc_cond_eval u_eval (
    .cond  (in_cond),
    .flags (cc_flags_t'(in_flags)),
    .taken (taken_c)
  );

  brc_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .pc     (in_pc),
    .disp   (in_disp),
    .target (target_c)
  );

  assign is_always = (in_cond == CODE_ALWAYS);

  brc_annul_ctl u_annul (
    .annul     (in_annul),
    .taken     (taken_c),
    .is_always (is_always),
    .squash    (squash_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_taken  <= taken_c;
      out_target <= target_c;
      out_squash <= squash_c;
      out_flags  <= in_flags;
    end
  end

  p_ready_when_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  p_accept_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_taken) &&
      $stable(out_target) && $stable(out_squash) && $stable(out_flags));
endmodule

// File: tb/brc_unit_test.sv
`timescale 1ns/1ps
module brc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_annul, out_valid, out_ready;
  logic [3:0]  in_cond, in_flags, out_flags;
  logic [21:0] in_disp;
  logic [31:0] in_pc, out_target;
  logic        out_taken, out_squash;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  brc_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cond(in_cond), .in_annul(in_annul), .in_disp(in_disp), .in_pc(in_pc),
    .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_target(out_target), .out_squash(out_squash),
    .out_flags(out_flags)
  );

  function automatic logic ref_taken(logic [3:0] c, logic [3:0] f);
    logic n, z, v, cy, b;
    {n, z, v, cy} = f;
    case (c[2:0])
      3'd0: b = 1'b0;
      3'd1: b = z;
      3'd2: b = z | (n ^ v);
      3'd3: b = n ^ v;
      3'd4: b = cy | z;
      3'd5: b = cy;
      3'd6: b = n;
      default: b = v;
    endcase
    return b ^ c[3];
  endfunction

  function automatic logic [31:0] ref_target(logic [31:0] pc, logic [21:0] d);
    return pc + {{8{d[21]}}, d, 2'b00};
  endfunction

  function automatic string cond_tag(logic [3:0] c);
    case (c[2:0])
      3'd0: return "R4";
      3'd1, 3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [3:0] c, logic a, logic [21:0] d, logic [31:0] pc,
                      logic [3:0] f, bit hold);
    logic et, es;
    logic [31:0] eg;
    et = ref_taken(c, f);
    eg = ref_target(pc, d);
    es = a & (~et | (c == 4'h8));
    @(negedge clk);
    in_cond = c; in_annul = a; in_disp = d; in_pc = pc; in_flags = f;
    in_valid = 1'b1; out_ready = 1'b0;
    chk(in_ready == 1'b1, "R2 ready when empty", 32'(in_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R2 result shows", 32'(out_valid), 32'd1);
    chk(in_ready == 1'b0, "R2 ready low when stalled", 32'(in_ready), 32'd0);
    if (hold) begin
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b1 && out_target == eg && out_taken == et,
          "R3 held result", out_target, eg);
    end
    chk(out_taken == et, cond_tag(c), 32'(out_taken), 32'(et));
    chk(out_target == eg, "R8 target", out_target, eg);
    chk(out_squash == es, a ? "R10 squash" : "R9 squash", 32'(out_squash), 32'(es));
    chk(out_flags == f, "R11 flags", 32'(out_flags), 32'(f));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_cond = '0; in_annul = 1'b0; in_disp = '0; in_pc = '0; in_flags = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);

    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        send(4'(c), 1'b0, 22'h1, 32'h1000, 4'(f), 1'b0);
    send(4'h8, 1'b1, 22'h10, 32'h2000, 4'h0, 1'b0);
    send(4'h0, 1'b1, 22'h10, 32'h2000, 4'hF, 1'b0);
    send(4'h1, 1'b1, 22'h4, 32'h3000, 4'h4, 1'b0);
    send(4'h1, 1'b1, 22'h4, 32'h3000, 4'h0, 1'b0);
    send(4'h3, 1'b0, 22'h1FFFFF, 32'h0000_0100, 4'h8, 1'b1);
    send(4'h8, 1'b0, 22'h200000, 32'h0000_0004, 4'h0, 1'b0);
    send(4'h8, 1'b0, 22'h3FFFFF, 32'h0000_0000, 4'h0, 1'b0);
    send(4'h8, 1'b0, 22'h1FFFFF, 32'hFFFF_FFF0, 4'h0, 1'b1);

    for (int i = 0; i < 400; i++)
      send(4'($urandom), 1'($urandom), 22'($urandom), $urandom, 4'($urandom),
           1'($urandom));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule